// File: doc/BRIEF.md
# Oversampled UART Receiver with Per-Character Status and Address Filtering

This block recovers characters from an asynchronous serial line. The line is sampled 16 times per bit, or 8 times when the fast mode input is high. A start bit is accepted only when a majority vote of three samples around mid-bit reads low. Each later bit is decided by the same three-sample vote. A completed character enters a two-deep receive queue. A character that finishes while the queue is full waits in a one-character holding register.

Every queued character keeps its own framing-error and parity-error status. It also keeps an overrun mark, which is set on the newest queued character when received data had to be thrown away. The host sees the head character and its status on the outputs and pops it with a one-cycle read strobe.

In address mode, frames carry nine data bits. A frame whose ninth bit is zero is discarded before it reaches the queue. An availability output, qualified by an interrupt enable, serves as the receive interrupt.

Top module: `mpc_uart_rx`

## Requirements
- R1: After reset, rx_avail, irq, rx_data, rx_ferr, rx_perr and rx_ovr are all zero.
- R2: A frame is a low start bit, then 8 data bits (9 in address mode) least-significant bit first, then an optional parity bit, then one stop bit. The data is presented on rx_data with rx_avail high. The unused bit 8 reads zero when not in address mode.
- R3: rx_ferr for a character is 1 when its stop bit was sampled low, and 0 when it was sampled high.
- R4: When par_en is high at the start of a frame, a parity bit follows the data. Parity is even when par_odd=0 and odd when par_odd=1, computed over all data bits. rx_perr is 1 exactly when the received parity does not match.
- R5: When par_en is low, no parity bit is expected and rx_perr reads 0.
- R6: Up to two characters are queued and read in arrival order. A pulse on rd removes the head, and each character's flags travel with it.
- R7: An overrun occurs when the queue holds two characters, a third complete character waits in the holding register, and a new start bit is confirmed. The waiting character is then lost, and rx_ovr is set on the newest queued character until that character is read.
- R8: In address mode (addr_mode=1), a frame whose ninth bit is 0 never enters the queue. A frame whose ninth bit is 1 is kept.
- R9: With dbl_speed=1, bits are 8 ticks long instead of 16, and reception stays correct at that rate.
- R10: A low pulse that is gone before the mid-bit vote is a false start. It produces no character, and the receiver is ready for the next real frame.
- R11: irq equals rx_avail while irq_en=1 and stays 0 while irq_en=0.
- R12: A rd pulse while the queue is empty has no effect on later reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| dbl_speed | input | 1 | 8x oversampling when high, 16x when low |
| par_en | input | 1 | Expect and check a parity bit |
| par_odd | input | 1 | Odd parity when high, even when low |
| addr_mode | input | 1 | Nine-bit frames, keep address frames only |
| irq_en | input | 1 | Receive interrupt enable |
| rd | input | 1 | Pop the head character |
| rx_data | output | 9 | Head character |
| rx_ferr | output | 1 | Head framing error |
| rx_perr | output | 1 | Head parity error |
| rx_ovr | output | 1 | Head overrun mark |
| rx_avail | output | 1 | Queue not empty |
| irq | output | 1 | Receive interrupt |

## Verification
Frames are sent with alternating and lopsided bit patterns, in both oversampling rates, with even, odd and no parity. This separates bit-order and rate faults from parity faults. Good and bad stop and parity bits are mixed within one queue, which shows whether the status travels with its own character or leaks to a neighbour. A four-frame burst without reads tells a correct overrun (the held character lost, the mark on the second) from a misplaced mark or a lost queue entry. Short low glitches and address-mode data frames must leave the queue untouched.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int unsigned OS_SLOW = 16;
    localparam int unsigned OS_FAST = 8;
    localparam int unsigned DW      = 9;

    typedef enum logic { RX_IDLE, RX_ACTIVE } rx_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          nine;
        logic          ferr;
        logic          perr;
    } rx_frame_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          ferr;
        logic          perr;
        logic          ovr;
    } rx_entry_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int unsigned TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == LAST) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      dbl,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      nine_en,
    output logic      start_ok,
    output logic      done,
    output rx_frame_t frame
);
    rx_state_e  state;
    logic [3:0] phase, bitidx, mid, os_last, nbits, par_idx;
    logic [1:0] votes;
    logic [8:0] shreg, dword;
    logic       c_dbl, c_par, c_odd, c_nine, par_bit, maj, in_win;

    always_comb begin
        os_last = c_dbl ? 4'(OS_FAST - 1) : 4'(OS_SLOW - 1);
        mid     = c_dbl ? 4'(OS_FAST / 2) : 4'(OS_SLOW / 2);
        nbits   = c_nine ? 4'd9 : 4'd8;
        par_idx = nbits + 4'd1;
        in_win  = (phase == mid - 4'd1) || (phase == mid) || (phase == mid + 4'd1);
        maj     = vote3({votes, rxd});
        dword   = c_nine ? shreg : {1'b0, shreg[8:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            phase    <= '0;
            bitidx   <= '0;
            votes    <= 2'b11;
            shreg    <= '0;
            par_bit  <= 1'b0;
            {c_dbl, c_par, c_odd, c_nine} <= '0;
            start_ok <= 1'b0;
            done     <= 1'b0;
            frame    <= '0;
        end else begin
            start_ok <= 1'b0;
            done     <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE) begin
                    if (!rxd) begin
                        state  <= RX_ACTIVE;
                        phase  <= '0;
                        bitidx <= '0;
                        {c_dbl, c_par, c_odd, c_nine} <= {dbl, par_en, par_odd, nine_en};
                    end
                end else begin
                    if (in_win) votes <= {votes[0], rxd};
                    if (phase == mid + 4'd1) begin
                        if (bitidx == 4'd0) begin
                            if (maj) state <= RX_IDLE;
                            else     start_ok <= 1'b1;
                        end else if (bitidx <= nbits) begin
                            shreg <= {maj, shreg[8:1]};
                        end else if (c_par && bitidx == par_idx) begin
                            par_bit <= maj;
                        end else begin
                            done       <= 1'b1;
                            frame.data <= dword;
                            frame.nine <= c_nine;
                            frame.ferr <= ~maj;
                            frame.perr <= c_par & ((^dword) ^ par_bit ^ c_odd);
                            state      <= RX_IDLE;
                        end
                    end
                    if (phase == os_last) begin
                        phase  <= '0;
                        bitidx <= bitidx + 4'd1;
                    end else begin
                        phase  <= phase + 4'd1;
                    end
                end
            end
        end
    end

    a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> state == RX_IDLE);
    a_r10_start_from_active: assert property (@(posedge clk) disable iff (rst)
        start_ok |-> state == RX_ACTIVE);
endmodule

// File: rtl/uart_rx_buf2.sv
module uart_rx_buf2
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  rx_entry_t push_ent,
    input  logic      pop,
    input  logic      ovr_mark,
    output logic [1:0] count,
    output rx_entry_t head
);
    localparam logic [1:0] FULL = 2'(DEPTH);

    rx_entry_t ent [DEPTH];
    rx_entry_t nxt [DEPTH];
    logic [1:0] c;
    logic pop_ok;

    assign pop_ok = pop && count != 2'd0;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) nxt[i] = ent[i];
        c = count;
        if (pop_ok) begin
            for (int i = 0; i < DEPTH - 1; i++) nxt[i] = ent[i+1];
            c = count - 2'd1;
        end
        if (push && c < FULL) begin
            for (int i = 0; i < DEPTH; i++) if (c == 2'(i)) nxt[i] = push_ent;
            c = c + 2'd1;
        end
        if (ovr_mark && c != 2'd0) begin
            for (int i = 0; i < DEPTH; i++) if (c == 2'(i + 1)) nxt[i].ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            count <= c;
            for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
        end
    end

    assign head = ent[0];

    a_r6_push_not_full: assert property (@(posedge clk) disable iff (rst)
        push |-> count != FULL);
    a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (pop_ok && !push) |=> count == $past(count) - 2'd1);
    a_r7_mark_when_full: assert property (@(posedge clk) disable iff (rst)
        ovr_mark |-> count == FULL);
endmodule

// File: rtl/mpc_uart_rx.sv
module mpc_uart_rx
    import uart_rx_pkg::*;
#(
    parameter int unsigned TICK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       dbl_speed,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       addr_mode,
    input  logic       irq_en,
    input  logic       rd,
    output logic [8:0] rx_data,
    output logic       rx_ferr,
    output logic       rx_perr,
    output logic       rx_ovr,
    output logic       rx_avail,
    output logic       irq
);
    logic [1:0] sync;
    logic       tick, start_ok, done, done_keep, full, push, ovr_mark, pend_vld;
    logic [1:0] count;
    rx_frame_t  frame, pend, push_rec;
    rx_entry_t  push_ent, head;

    always_ff @(posedge clk) begin
        if (rst) sync <= 2'b11;
        else     sync <= {sync[0], rxd};
    end

    uart_rx_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    uart_rx_frame u_frame (
        .clk(clk), .rst(rst), .tick(tick), .rxd(sync[1]),
        .dbl(dbl_speed), .par_en(par_en), .par_odd(par_odd), .nine_en(addr_mode),
        .start_ok(start_ok), .done(done), .frame(frame)
    );

    assign done_keep = done && (!frame.nine || frame.data[8]);
    assign full      = (count == 2'd2);
    assign ovr_mark  = start_ok && full && pend_vld;
    assign push      = (pend_vld || done_keep) && !full;
    assign push_rec  = pend_vld ? pend : frame;
    assign push_ent  = '{data: push_rec.data, ferr: push_rec.ferr, perr: push_rec.perr, ovr: 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            pend     <= '0;
        end else if (ovr_mark) begin
            pend_vld <= 1'b0;
        end else if (done_keep && (full || pend_vld)) begin
            pend     <= frame;
            pend_vld <= 1'b1;
        end else if (pend_vld && !full) begin
            pend_vld <= 1'b0;
        end
    end

    uart_rx_buf2 #(.DEPTH(2)) u_buf (
        .clk(clk), .rst(rst), .push(push), .push_ent(push_ent), .pop(rd),
        .ovr_mark(ovr_mark), .count(count), .head(head)
    );

    assign rx_avail = (count != 2'd0);
    assign rx_data  = rx_avail ? head.data : '0;
    assign rx_ferr  = rx_avail & head.ferr;
    assign rx_perr  = rx_avail & head.perr;
    assign rx_ovr   = rx_avail & head.ovr;
    assign irq      = rx_avail & irq_en;

    a_r8_only_addr_queued: assert property (@(posedge clk) disable iff (rst)
        push |-> (!push_rec.nine || push_rec.data[8]));
    a_r7_hold_dropped: assert property (@(posedge clk) disable iff (rst)
        ovr_mark |=> !pend_vld);
endmodule

// File: tb/test_mpc_uart_rx.sv
module test_mpc_uart_rx;
    localparam int TDIV = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, rxd, dbl_speed, par_en, par_odd, addr_mode, irq_en, rd;
    logic [8:0] rx_data;
    logic rx_ferr, rx_perr, rx_ovr, rx_avail, irq;

    mpc_uart_rx #(.TICK_DIV(TDIV)) i_mpc_uart_rx (
        .clk(clk), .rst(rst), .rxd(rxd), .dbl_speed(dbl_speed), .par_en(par_en),
        .par_odd(par_odd), .addr_mode(addr_mode), .irq_en(irq_en), .rd(rd),
        .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr),
        .rx_avail(rx_avail), .irq(irq)
    );

    int checks = 0;
    int errors = 0;

    typedef struct { logic [8:0] d; bit fe; bit pe; bit ov; } exp_t;
    exp_t q[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input bit nine, input bit par, input bit odd,
                        input bit bad_par, input bit bad_stop, input bit fast);
        int bt = (fast ? 8 : 16) * TDIV;
        int nb = nine ? 9 : 8;
        logic p;
        dbl_speed = fast; par_en = par; par_odd = odd; addr_mode = nine;
        rxd = 1'b0; hold(bt);
        for (int i = 0; i < nb; i++) begin rxd = d[i]; hold(bt); end
        if (par) begin
            p = (nine ? ^d : ^d[7:0]) ^ odd ^ bad_par;
            rxd = p; hold(bt);
        end
        rxd = ~bad_stop; hold(bt);
        rxd = 1'b1; hold(bt + 4);
    endtask

    task automatic expect_char(input logic [8:0] d, input bit fe, input bit pe, input bit ov);
        exp_t e;
        e.d = d; e.fe = fe; e.pe = pe; e.ov = ov;
        q.push_back(e);
    endtask

    task automatic pop_check(input string req);
        exp_t e = q.pop_front();
        chk(req, "avail", int'(rx_avail), 1);
        chk(req, "data", int'(rx_data), int'(e.d));
        chk(req, "ferr", int'(rx_ferr), int'(e.fe));
        chk(req, "perr", int'(rx_perr), int'(e.pe));
        chk(req, "ovr", int'(rx_ovr), int'(e.ov));
        rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; dbl_speed = 0; par_en = 0; par_odd = 0;
        addr_mode = 0; irq_en = 0; rd = 0;
        hold(5);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "avail", int'(rx_avail), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "data", int'(rx_data), 0);
        chk("R1", "flags", int'({rx_ferr, rx_perr, rx_ovr}), 0);

        // R2 R5 R11 plain frame, interrupt enabled
        irq_en = 1;
        send(9'h0A5, 0, 0, 0, 0, 0, 0); expect_char(9'h0A5, 0, 0, 0);
        chk("R11", "irq on", int'(irq), 1);
        pop_check("R2 R5");
        chk("R11", "irq after read", int'(irq), 0);
        chk("R6", "empty after read", int'(rx_avail), 0);

        // R11 interrupt disabled
        irq_en = 0;
        send(9'h003, 0, 0, 0, 0, 0, 0); expect_char(9'h003, 0, 0, 0);
        chk("R11", "irq masked", int'(irq), 0);
        pop_check("R2");

        // R3 framing error then good stop
        send(9'h0F0, 0, 0, 0, 0, 1, 0); expect_char(9'h0F0, 1, 0, 0);
        pop_check("R3");
        send(9'h00F, 0, 0, 0, 0, 0, 0); expect_char(9'h00F, 0, 0, 0);
        pop_check("R3");

        // R4 parity even good, even bad, odd good, odd bad
        send(9'h037, 0, 1, 0, 0, 0, 0); expect_char(9'h037, 0, 0, 0);
        pop_check("R4");
        send(9'h037, 0, 1, 0, 1, 0, 0); expect_char(9'h037, 0, 1, 0);
        pop_check("R4");
        send(9'h0C1, 0, 1, 1, 0, 0, 0); expect_char(9'h0C1, 0, 0, 0);
        pop_check("R4");
        send(9'h0C1, 0, 1, 1, 1, 0, 0); expect_char(9'h0C1, 0, 1, 0);
        pop_check("R4");

        // R6 two queued with different status
        send(9'h011, 0, 1, 0, 1, 0, 0); expect_char(9'h011, 0, 1, 0);
        send(9'h0EE, 0, 0, 0, 0, 1, 0); expect_char(9'h0EE, 1, 0, 0);
        pop_check("R6");
        pop_check("R6");
        chk("R6", "empty", int'(rx_avail), 0);

        // R7 overrun: four frames, third lost, mark on second
        send(9'h021, 0, 0, 0, 0, 0, 0); expect_char(9'h021, 0, 0, 0);
        send(9'h042, 0, 0, 0, 0, 0, 0); expect_char(9'h042, 0, 0, 1);
        send(9'h063, 0, 0, 0, 0, 0, 0);
        send(9'h084, 0, 0, 0, 0, 0, 0); expect_char(9'h084, 0, 0, 0);
        pop_check("R7");
        pop_check("R7");
        pop_check("R7");
        chk("R7", "empty", int'(rx_avail), 0);

        // R8 address mode
        send(9'h13C, 1, 0, 0, 0, 0, 0); expect_char(9'h13C, 0, 0, 0);
        send(9'h055, 1, 0, 0, 0, 0, 0);
        pop_check("R8");
        chk("R8", "data frame dropped", int'(rx_avail), 0);
        send(9'h1FF, 1, 1, 1, 0, 0, 0); expect_char(9'h1FF, 0, 0, 0);
        pop_check("R8");

        // R9 fast mode
        send(9'h096, 0, 0, 0, 0, 0, 1); expect_char(9'h096, 0, 0, 0);
        send(9'h0FE, 0, 1, 0, 0, 0, 1); expect_char(9'h0FE, 0, 0, 0);
        pop_check("R9");
        pop_check("R9");

        // R10 false start
        dbl_speed = 0; par_en = 0; addr_mode = 0;
        rxd = 1'b0; hold(4 * TDIV); rxd = 1'b1; hold(40 * TDIV);
        chk("R10", "no char", int'(rx_avail), 0);
        send(9'h05A, 0, 0, 0, 0, 0, 0); expect_char(9'h05A, 0, 0, 0);
        pop_check("R10");

        // R12 read strobe on empty queue
        rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
        chk("R12", "still empty", int'(rx_avail), 0);
        send(9'h0C3, 0, 0, 0, 0, 0, 0); expect_char(9'h0C3, 0, 0, 0);
        pop_check("R12");
        chk("R12", "single char", int'(rx_avail), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule